// File: doc/BRIEF.md
# Timing-Pulse Control-Pulse Sequencer

This block steps a small 16-bit register-transfer datapath through memory cycles. Each cycle is split into twelve timing pulses. In every pulse a combinational matrix, indexed by the current sub-sequence and pulse number, raises a few register read and write strobes. Fixed memory strobes are OR-ed in at set pulses of every cycle. Four registers (A, L, B, Z) and an external data port share one write bus. A read strobe places a source on the bus, and a write strobe loads the bus into a register at the clock edge that closes the pulse.

A controller raises `start_i` with a sub-sequence code. The generator then runs one full cycle of that code. At the close of pulse 12 it either takes the next code, when `start_i` is still high, or returns to idle. An instruction that needs several sub-sequences runs them back to back, one cycle each.

Top module: `tps_seq`

## Requirements
- R1: After reset `tp_o` is 1, `cp_o` is all zero, `eoc_o` is 0 and registers A, L, B and Z hold zero.
- R2: While a cycle runs, `tp_o` advances by one on every clock from 1 to 12. `eoc_o` is high only during pulse 12.
- R3: When idle, `tp_o` holds at 1 and `cp_o` is zero. The sequencer is idle after reset, and after pulse 12 closes with `start_i` low.
- R4: `sseq_i` is sampled only on an idle clock with `start_i` high, or on the edge that closes pulse 12. A change at any other time has no effect on the running cycle.
- R5: Memory strobes fire in every running cycle, whatever the code: `cp_o[9]` (address) in pulse 1, `cp_o[10]` (read) in pulse 4 and `cp_o[11]` (write) in pulse 10.
- R6: At most five register strobes (`cp_o[8:0]`) are active in any pulse.
- R7: Strobe bits: reads are RA=0, RL=1, RB=2, RZ=3 and RD=4, where RD drives `data_i`. Writes are WA=5, WL=6, WB=7 and WZ=8. The bus is the OR of all read sources and reads zero when no read is active. A write loads the bus at the edge that ends its pulse.
- R8: Sub-sequence codes: 0 does nothing. 1 loads A from data in pulse 6 (RD,WA). 2 loads L from data in pulse 6 (RD,WL). 3 copies A to B in pulse 3 (RA,WB). 4 swaps A and L through B: pulse 2 RA,WB, then pulse 5 RL,WA, then pulse 8 RB,WL. 5 sets Z to A OR L in pulse 7 (RA,RL,WZ). 6 clears A in pulse 9 (WA alone). 7 writes data to all four registers in pulse 11 (RD,WA,WL,WB,WZ).
- R9: With `start_i` high at the close of pulse 12, the next cycle starts at pulse 1 on the next clock with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start or continue with a sub-sequence |
| sseq_i | input | 3 | Sub-sequence code |
| data_i | input | 16 | External data driven onto the bus by RD |
| tp_o | output | 4 | Current timing pulse, 1 to 12 |
| cp_o | output | 12 | Active control-pulse vector |
| eoc_o | output | 1 | End-of-cycle strobe during pulse 12 |
| bus_o | output | 16 | Write bus value |
| a_o | output | 16 | Register A |
| l_o | output | 16 | Register L |
| b_o | output | 16 | Register B |
| z_o | output | 16 | Register Z |

## Verification
A vector table runs each code over chosen data words and compares the registers with a model after every cycle. Single-source copies show that the right register is routed. The swap and the OR show that pulses are ordered inside a cycle and that bus sources are combined. Clear with no read shows that an undriven bus reads zero. Directed cases trace every pulse of a broadcast cycle to check the memory strobes and the five-strobe maximum. They also change the code in mid-cycle to show it is ignored, and hold start high to show that the next cycle follows with no gap.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int TP_N   = 12;
  localparam int TP_W   = $clog2(TP_N + 1);
  localparam int SS_W   = 3;
  localparam int NREG   = 4;
  localparam int CP_N   = 12;
  // read strobes, register order A,L,B,Z
  localparam int CP_RA  = 0;
  localparam int CP_RD  = 4;
  // write strobes, same register order
  localparam int CP_WA  = 5;
  localparam int CP_MAD = 9;
  localparam int CP_MRD = 10;
  localparam int CP_MWR = 11;
  localparam int TP_MAD = 1;
  localparam int TP_MRD = 4;
  localparam int TP_MWR = 10;

  typedef enum logic [SS_W-1:0] {
    SS_NOP  = 3'd0,
    SS_LDA  = 3'd1,
    SS_LDL  = 3'd2,
    SS_A2B  = 3'd3,
    SS_SWAP = 3'd4,
    SS_ORAL = 3'd5,
    SS_CLRA = 3'd6,
    SS_BCST = 3'd7
  } ss_e;
endpackage

// File: rtl/tps_tpgen.sv
module tps_tpgen
  import tps_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [SS_W-1:0] sseq_i,
  output logic            active_o,
  output logic [TP_W-1:0] tp_o,
  output ss_e             ss_o
);
  logic [TP_W-1:0] tp_q;
  logic            act_q;
  ss_e             ss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tp_q  <= TP_W'(1);
      act_q <= 1'b0;
      ss_q  <= SS_NOP;
    end else if (!act_q || tp_q == TP_W'(TP_N)) begin
      tp_q  <= TP_W'(1);
      act_q <= start_i;
      if (start_i) ss_q <= ss_e'(sseq_i);
    end else begin
      tp_q <= tp_q + TP_W'(1);
    end
  end

  assign active_o = act_q;
  assign tp_o     = tp_q;
  assign ss_o     = ss_q;
endmodule

// File: rtl/tps_cpmatrix.sv
module tps_cpmatrix
  import tps_pkg::*;
(
  input  logic            active_i,
  input  ss_e             ss_i,
  input  logic [TP_W-1:0] tp_i,
  output logic [CP_N-1:0] cp_o
);
  localparam int RL = CP_RA + 1, RB = CP_RA + 2;
  localparam int WL = CP_WA + 1, WB = CP_WA + 2, WZ = CP_WA + 3;

  logic [CP_N-1:0] mtx;
  logic [CP_N-1:0] mem;

  always_comb begin
    mtx = '0;
    unique case (ss_i)
      SS_LDA:  if (tp_i == TP_W'(6)) begin mtx[CP_RD] = 1'b1; mtx[CP_WA] = 1'b1; end
      SS_LDL:  if (tp_i == TP_W'(6)) begin mtx[CP_RD] = 1'b1; mtx[WL] = 1'b1; end
      SS_A2B:  if (tp_i == TP_W'(3)) begin mtx[CP_RA] = 1'b1; mtx[WB] = 1'b1; end
      SS_SWAP: begin
        if (tp_i == TP_W'(2)) begin mtx[CP_RA] = 1'b1; mtx[WB] = 1'b1; end
        if (tp_i == TP_W'(5)) begin mtx[RL] = 1'b1; mtx[CP_WA] = 1'b1; end
        if (tp_i == TP_W'(8)) begin mtx[RB] = 1'b1; mtx[WL] = 1'b1; end
      end
      SS_ORAL: if (tp_i == TP_W'(7)) begin
        mtx[CP_RA] = 1'b1; mtx[RL] = 1'b1; mtx[WZ] = 1'b1;
      end
      SS_CLRA: if (tp_i == TP_W'(9)) mtx[CP_WA] = 1'b1;
      SS_BCST: if (tp_i == TP_W'(11)) begin
        mtx[CP_RD] = 1'b1; mtx[CP_WA] = 1'b1; mtx[WL] = 1'b1;
        mtx[WB] = 1'b1; mtx[WZ] = 1'b1;
      end
      default: mtx = '0;
    endcase
  end

  always_comb begin
    mem = '0;
    mem[CP_MAD] = (tp_i == TP_W'(TP_MAD));
    mem[CP_MRD] = (tp_i == TP_W'(TP_MRD));
    mem[CP_MWR] = (tp_i == TP_W'(TP_MWR));
  end

  assign cp_o = active_i ? (mtx | mem) : '0;
endmodule

// File: rtl/tps_regs.sv
module tps_regs
  import tps_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CP_N-1:0]   cp_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [DATA_W-1:0] rq_o [NREG]
);
  logic [DATA_W-1:0] src [NREG+1];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              q <= '0;
      else if (cp_i[CP_WA + k]) q <= bus_o;
    end
    assign src[k]  = cp_i[CP_RA + k] ? q : '0;
    assign rq_o[k] = q;
  end
  assign src[NREG] = cp_i[CP_RD] ? data_i : '0;

  always_comb begin
    bus_o = '0;
    for (int i = 0; i <= NREG; i++) bus_o = bus_o | src[i];
  end
endmodule

// File: rtl/tps_seq.sv
module tps_seq
  import tps_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SS_W-1:0]   sseq_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [TP_W-1:0]   tp_o,
  output logic [CP_N-1:0]   cp_o,
  output logic              eoc_o,
  output logic [DATA_W-1:0] bus_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] l_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] z_o
);
  logic              active;
  ss_e               ss;
  logic [DATA_W-1:0] rq [NREG];

  tps_tpgen u_gen (
    .clk_i, .rst_ni, .start_i, .sseq_i,
    .active_o(active), .tp_o(tp_o), .ss_o(ss)
  );

  tps_cpmatrix u_mtx (
    .active_i(active), .ss_i(ss), .tp_i(tp_o), .cp_o(cp_o)
  );

  tps_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .cp_i(cp_o), .data_i, .bus_o(bus_o), .rq_o(rq)
  );

  assign eoc_o = active && (tp_o == TP_W'(TP_N));
  assign a_o = rq[0];
  assign l_o = rq[1];
  assign b_o = rq[2];
  assign z_o = rq[3];
endmodule

// File: rtl/tps_seq_chk.sv
module tps_seq_chk
  import tps_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              active,
  input logic [TP_W-1:0]   tp_o,
  input logic [CP_N-1:0]   cp_o,
  input logic              eoc_o,
  input logic [DATA_W-1:0] bus_o,
  input logic [DATA_W-1:0] a_o
);
  AST_TP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tp_o >= TP_W'(1) && tp_o <= TP_W'(TP_N)); // R2
  AST_TP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && tp_o != TP_W'(TP_N)) |=> tp_o == $past(tp_o) + TP_W'(1)); // R2
  AST_TP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> tp_o == TP_W'(1)); // R9
  AST_EOC_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> tp_o == TP_W'(TP_N)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (cp_o == '0 && tp_o == TP_W'(1))); // R3
  AST_MEM_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (cp_o[CP_MAD] == (tp_o == TP_W'(TP_MAD)) &&
                cp_o[CP_MRD] == (tp_o == TP_W'(TP_MRD)) &&
                cp_o[CP_MWR] == (tp_o == TP_W'(TP_MWR)))); // R5
  AST_MAX_FIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cp_o[CP_MAD-1:0]) <= 5); // R6
  AST_BUS_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_o[CP_RD:0] == '0) |-> bus_o == '0); // R7
  AST_WRITE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_o[CP_WA] |=> a_o == $past(bus_o)); // R7
endmodule

bind tps_seq tps_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .active(active), .tp_o(tp_o),
  .cp_o(cp_o), .eoc_o(eoc_o), .bus_o(bus_o), .a_o(a_o)
);

// File: tb/sim_tps_seq.sv
module sim_tps_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  sseq_i = 3'd0;
  logic [15:0] data_i = 16'h0;
  logic [3:0]  tp_o;
  logic [11:0] cp_o;
  logic        eoc_o;
  logic [15:0] bus_o, a_o, l_o, b_o, z_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_a = 0, m_l = 0, m_b = 0, m_z = 0;

  // {code, data}
  localparam logic [18:0] VEC [12] = '{
    {3'd1, 16'h1234}, {3'd2, 16'h00F0}, {3'd3, 16'h0000}, {3'd5, 16'h0000},
    {3'd4, 16'h0000}, {3'd6, 16'h0000}, {3'd5, 16'h0000}, {3'd7, 16'hBEEF},
    {3'd0, 16'hFFFF}, {3'd1, 16'h8001}, {3'd2, 16'h7E00}, {3'd5, 16'h0000}
  };

  tps_seq u0 (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(logic [2:0] c, logic [15:0] d);
    logic [15:0] t;
    case (c)
      3'd1: m_a = d;
      3'd2: m_l = d;
      3'd3: m_b = m_a;
      3'd4: begin t = m_a; m_b = t; m_a = m_l; m_l = t; end
      3'd5: m_z = m_a | m_l;
      3'd6: m_a = '0;
      3'd7: begin m_a = d; m_l = d; m_b = d; m_z = d; end
      default: ;
    endcase
  endtask

  task automatic chk_regs(string req);
    chk(req, a_o, m_a); chk(req, l_o, m_l); chk(req, b_o, m_b); chk(req, z_o, m_z);
  endtask

  // one cycle, start dropped after the latch edge
  task automatic run1(logic [2:0] c, logic [15:0] d);
    @(negedge clk_i); sseq_i = c; data_i = d; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (11) @(negedge clk_i);
    @(negedge clk_i);
    model(c, d);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk("R1", {12'h0, tp_o}, 16'd1);
    chk("R1", {4'h0, cp_o}, 16'h0);
    chk("R1", {15'h0, eoc_o}, 16'h0);
    chk_regs("R1");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R3 idle holds without start
    chk("R3", {12'h0, tp_o}, 16'd1);
    chk("R3", {4'h0, cp_o}, 16'h0);

    // R8 R7 vector table
    for (int i = 0; i < 12; i++) begin
      run1(VEC[i][18:16], VEC[i][15:0]);
      chk_regs("R8");
      chk("R3", {4'h0, cp_o}, 16'h0);
    end

    // R2 R5 R6 pulse trace of broadcast cycle
    @(negedge clk_i); sseq_i = 3'd7; data_i = 16'h5A5A; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    for (int t = 1; t <= 12; t++) begin
      logic [11:0] e;
      e = '0;
      if (t == 1)  e[9] = 1'b1;
      if (t == 4)  e[10] = 1'b1;
      if (t == 10) e[11] = 1'b1;
      if (t == 11) e[8:4] = 5'b11111;
      chk("R2", {12'h0, tp_o}, 16'(t));
      chk("R2", {15'h0, eoc_o}, {15'h0, t == 12});
      chk("R5", {4'h0, cp_o}, {4'h0, e});
      if (t == 11) chk("R7", bus_o, 16'h5A5A);
      if (t == 3)  chk("R7", bus_o, 16'h0000);
      @(negedge clk_i);
    end
    model(3'd7, 16'h5A5A);
    chk_regs("R6");
    chk("R3", {12'h0, tp_o}, 16'd1);

    // R4 code change mid-cycle ignored
    run1(3'd2, 16'h0F0F);
    @(negedge clk_i); sseq_i = 3'd1; data_i = 16'hC3C3; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    sseq_i = 3'd6;
    repeat (9) @(negedge clk_i);
    model(3'd1, 16'hC3C3);
    chk_regs("R4");

    // R9 back-to-back: LDL then SWAP with no gap
    @(negedge clk_i); sseq_i = 3'd2; data_i = 16'h1111; start_i = 1'b1;
    @(negedge clk_i);
    sseq_i = 3'd4;
    repeat (11) @(negedge clk_i);
    chk("R9", {15'h0, eoc_o}, 16'h1);
    @(negedge clk_i);
    model(3'd2, 16'h1111);
    chk("R9", {12'h0, tp_o}, 16'd1);
    chk("R9", {4'h0, cp_o}, 16'h0200);
    chk_regs("R9");
    start_i = 1'b0;
    repeat (12) @(negedge clk_i);
    model(3'd4, 16'h1111);
    chk_regs("R9");
    chk("R3", {4'h0, cp_o}, 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule